// File: doc/BRIEF.md
# Scalar Bitfield Extractor

This unit pulls a contiguous group of bits out of a scalar source word and returns it right-aligned, either zero-filled or sign-filled above the field. It works on 32-bit or 64-bit data. A single 32-bit control word carries both the starting bit position and the field length. Next to the extracted value the unit produces one condition bit, which says whether the value is non-zero.

The data path is pure logic. Operands and results travel over a valid/ready stream pair. A beat is taken when `in_valid` and `in_ready` are both high on a rising clock edge. A result is delivered when `out_valid` and `out_ready` are both high. With `REG_OUT` = 0 (the default) the stream passes straight through: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so back-pressure reaches the producer in the same cycle. With `REG_OUT` = 1, one output register sits between the two sides. It accepts a new beat whenever it is empty or its current result is being taken. While its result is stalled, it holds that result and the condition bit unchanged.

Top module: `scalar_bfx`

## Requirements
- R1: Unsigned extraction: when `in_signed` = 0, the result holds source bits [off+len-1 : off] in its low `len` bits, and every higher bit is 0.
- R2: Signed extraction: when `in_signed` = 1, every result bit above the field copies the field's most significant bit.
- R3: The start position is `in_ctrl[4:0]` when `in_wide` = 0 (`in_ctrl[5]` then has no effect), and `in_ctrl[5:0]` when `in_wide` = 1.
- R4: The length is `in_ctrl[22:16]`, from 0 to 127. A length of 0 gives a result of 0 and a condition bit of 0.
- R5: When off+len is at least the data width (32 or 64), the field runs to the top bit of the word. The result is then the source shifted right by off: logical when unsigned, arithmetic when signed.
- R6: With `in_wide` = 1, all 64 bits of `in_data` and of `out_result` take part.
- R7: With `in_wide` = 0, `in_data[63:32]` has no effect and `out_result[63:32]` is 0.
- R8: `out_flag` is 1 exactly when `out_result` is non-zero.
- R9: The bits of `in_ctrl` outside [5:0] and [22:16] have no effect.
- R10: With `REG_OUT` = 0, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, and the result appears in the same cycle.
- R11: With `REG_OUT` = 1, `out_valid` is 0 after reset. A beat that is accepted appears at the output in the next cycle. While `out_valid` = 1 and `out_ready` = 0, the result and flag stay stable, and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand beat is present |
| in_ready | output | 1 | Unit can take an operand beat |
| in_data | input | 64 | Source word (low 32 bits used in narrow mode) |
| in_ctrl | input | 32 | Start position and length |
| in_wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| in_signed | input | 1 | 1 selects sign fill above the field |
| out_valid | output | 1 | Result beat is present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 64 | Extracted value |
| out_flag | output | 1 | Result is non-zero |

## Verification
The bench targets fields that cross the top of the word. A design that only masks by the length would leave sign bits that are wrong, or would pull in bits from above bit 31 in narrow mode. It sets the sixth position bit and stray control bits in narrow mode; a decoder that kept them would shift too far. It also covers a length of zero and a non-zero length whose field happens to be all zeros, where a flag computed before the narrow-mode truncation or before the zero-length clear would read 1 wrongly. Random stalls on `out_ready` show whether the registered stage drops, duplicates or changes a result while it is held.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int BFX_DATA_W  = 64;
  localparam int BFX_CTRL_W  = 32;
  localparam int BFX_LEN_LSB = 16;
  localparam int BFX_LEN_W   = 7;

  typedef enum logic {
    BFX_NARROW = 1'b0,
    BFX_WIDE   = 1'b1
  } bfx_width_e;

  typedef enum logic {
    BFX_ZERO_FILL = 1'b0,
    BFX_SIGN_FILL = 1'b1
  } bfx_fill_e;
endpackage

// File: rtl/bfx_field_decode.sv
module bfx_field_decode #(
  parameter int CTRL_W  = bfx_pkg::BFX_CTRL_W,
  parameter int OFF_W   = 6,
  parameter int LEN_LSB = bfx_pkg::BFX_LEN_LSB,
  parameter int LEN_W   = bfx_pkg::BFX_LEN_W
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  bfx_pkg::bfx_width_e width_sel,
  output logic [OFF_W-1:0]  off,
  output logic [LEN_W-1:0]  len
);
  localparam int NARROW_OFF_W = OFF_W - 1;

  logic ctrl_unused;
  assign ctrl_unused = ^ctrl;

  // Narrow mode drops the top position bit; wide mode keeps all of them.
  always_comb begin
    if (width_sel == bfx_pkg::BFX_WIDE) begin
      off = ctrl[OFF_W-1:0];
    end else begin
      off = {1'b0, ctrl[NARROW_OFF_W-1:0]};
    end
    len = ctrl[LEN_LSB+LEN_W-1:LEN_LSB];
  end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DATA_W = bfx_pkg::BFX_DATA_W,
  parameter int OFF_W  = $clog2(DATA_W),
  parameter int LEN_W  = bfx_pkg::BFX_LEN_W
) (
  input  logic [DATA_W-1:0] data,
  input  bfx_pkg::bfx_width_e width_sel,
  input  bfx_pkg::bfx_fill_e  fill_sel,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] result,
  output logic              nonzero
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EW     = (LEN_W > OFF_W + 1) ? LEN_W : OFF_W + 1;

  logic              is_wide;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] shifted;
  logic [EW-1:0]     width_act;
  logic [EW-1:0]     room;
  logic [EW-1:0]     len_x;
  logic [EW-1:0]     eff;
  logic [OFF_W-1:0]  top_idx;
  logic [DATA_W-1:0] keep;
  logic              fill_bit;
  logic [DATA_W-1:0] filled;

  assign is_wide = (width_sel == bfx_pkg::BFX_WIDE);

  // Narrow operands see only the low half of the source.
  assign src       = is_wide ? data : {{(DATA_W-HALF_W){1'b0}}, data[HALF_W-1:0]};
  assign shifted   = src >> off;
  assign width_act = is_wide ? EW'(DATA_W) : EW'(HALF_W);
  assign room      = width_act - EW'(off);
  assign len_x     = EW'(len);
  // A field longer than the bits left above the offset is cut at the word top.
  assign eff       = (len_x >= room) ? room : len_x;
  assign top_idx   = eff[OFF_W-1:0] - 1'b1;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
      assign keep[i] = (EW'(i) < eff);
    end
  endgenerate

  assign fill_bit = (fill_sel == bfx_pkg::BFX_SIGN_FILL) && shifted[top_idx];
  assign filled   = (shifted & keep) | (fill_bit ? ~keep : '0);

  always_comb begin
    if (len == '0) begin
      result = '0;
    end else if (is_wide) begin
      result = filled;
    end else begin
      result = {{(DATA_W-HALF_W){1'b0}}, filled[HALF_W-1:0]};
    end
  end

  assign nonzero = |result;
endmodule

// File: rtl/bfx_out_stage.sv
module bfx_out_stage #(
  parameter int DATA_W  = bfx_pkg::BFX_DATA_W,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_result,
  input  logic              in_flag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_flag
);
  generate
    if (REG_OUT) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] res_q;
      logic              flg_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          flg_q <= 1'b0;
        end else if (in_valid && in_ready) begin
          vld_q <= 1'b1;
          res_q <= in_result;
          flg_q <= in_flag;
        end else if (out_ready) begin
          vld_q <= 1'b0;
        end
      end

      assign out_valid  = vld_q;
      assign out_result = res_q;
      assign out_flag   = flg_q;

      AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flag))); // R11
      AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R11
      AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R11
    end else begin : g_pass
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_result = in_result;
      assign out_flag   = in_flag;

      AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == in_valid) && (in_ready == out_ready)); // R10
    end
  endgenerate

  AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flag == (out_result != '0))); // R8
endmodule

// File: rtl/scalar_bfx.sv
module scalar_bfx #(
  parameter int DATA_W  = bfx_pkg::BFX_DATA_W,
  parameter int CTRL_W  = bfx_pkg::BFX_CTRL_W,
  parameter int LEN_LSB = bfx_pkg::BFX_LEN_LSB,
  parameter int LEN_W   = bfx_pkg::BFX_LEN_W,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_wide,
  input  logic              in_signed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_flag
);
  localparam int OFF_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;

  bfx_pkg::bfx_width_e width_sel;
  bfx_pkg::bfx_fill_e  fill_sel;
  logic [OFF_W-1:0]    fld_off;
  logic [LEN_W-1:0]    fld_len;
  logic [DATA_W-1:0]   core_res;
  logic                core_nz;

  assign width_sel = in_wide   ? bfx_pkg::BFX_WIDE      : bfx_pkg::BFX_NARROW;
  assign fill_sel  = in_signed ? bfx_pkg::BFX_SIGN_FILL : bfx_pkg::BFX_ZERO_FILL;

  bfx_field_decode #(
    .CTRL_W (CTRL_W),
    .OFF_W  (OFF_W),
    .LEN_LSB(LEN_LSB),
    .LEN_W  (LEN_W)
  ) u_decode (
    .ctrl     (in_ctrl),
    .width_sel(width_sel),
    .off      (fld_off),
    .len      (fld_len)
  );

  bfx_extract #(
    .DATA_W(DATA_W),
    .OFF_W (OFF_W),
    .LEN_W (LEN_W)
  ) u_extract (
    .data     (in_data),
    .width_sel(width_sel),
    .fill_sel (fill_sel),
    .off      (fld_off),
    .len      (fld_len),
    .result   (core_res),
    .nonzero  (core_nz)
  );

  bfx_out_stage #(
    .DATA_W (DATA_W),
    .REG_OUT(REG_OUT)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_result (core_res),
    .in_flag   (core_nz),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_result(out_result),
    .out_flag  (out_flag)
  );

  AST_ZERO_LEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fld_len == '0) |-> (core_res == '0 && !core_nz)); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |-> (core_res[DATA_W-1:HALF_W] == '0)); // R7
  AST_NARROW_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |-> (fld_off < OFF_W'(HALF_W))); // R3
endmodule

// File: tb/scalar_bfx_test.sv
module scalar_bfx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    logic [63:0] res;
    logic        flag;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [31:0] in_ctrl = '0;
  logic        in_wide = 1'b0;
  logic        in_signed = 1'b0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_flag;
  logic [63:0] out_result;
  logic        c_in_ready, c_out_valid, c_out_flag;
  logic [63:0] c_out_result;

  int   tests = 0;
  int   fails = 0;
  bit   stall_en = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scalar_bfx #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_wide(in_wide), .in_signed(in_signed),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result), .out_flag(out_flag)
  );

  scalar_bfx #(.REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_wide(in_wide), .in_signed(in_signed),
    .out_valid(c_out_valid), .out_ready(out_ready), .out_result(c_out_result), .out_flag(c_out_flag)
  );

  // Bit-by-bit reference built from the requirement text.
  function automatic logic [64:0] model(logic [63:0] d, logic [31:0] c, bit w, bit s);
    int wd  = w ? 64 : 32;
    int off = w ? int'(c[5:0]) : int'(c[4:0]);
    int len = int'(c[22:16]);
    int top = (off + len >= wd) ? wd - 1 : off + len - 1;
    logic [63:0] r = '0;
    if (len != 0) begin
      for (int i = 0; i < wd; i++) begin
        if (i < len && off + i < wd) r[i] = d[off + i];
        else r[i] = s ? d[top] : 1'b0;
      end
    end
    return {(r != '0), r};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual flag=%0b res=%h expected flag=%0b res=%h",
               tag, act[64], act[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic send(input logic [63:0] d, input logic [31:0] c, input bit w, input bit s,
                      input string tag);
    logic [64:0] e;
    bit done;
    exp_t item;
    e = model(d, c, w, s);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_ctrl = c; in_wide = w; in_signed = s;
    #2;
    // R10: pass-through variant answers in the same cycle
    check(c_out_valid && (c_in_ready == out_ready) && c_out_result == e[63:0] && c_out_flag == e[64],
          {tag, " R10 comb"}, {c_out_flag, c_out_result}, e);
    done = 1'b0;
    while (!done) begin
      if (in_ready) begin
        item.res = e[63:0]; item.flag = e[64]; item.tag = tag;
        sb.push_back(item);
        done = 1'b1;
      end
      @(posedge clk);
      if (!done) begin
        @(negedge clk);
        #2;
      end
    end
    #1 in_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard on each delivered beat, checks held values on stalls.
  initial begin
    bit          was_stalled = 1'b0;
    logic [64:0] held = '0;
    exp_t        it;
    forever begin
      @(negedge clk);
      out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (was_stalled) begin
          // R11: a stalled result stays put
          check(out_valid && {out_flag, out_result} == held, "R11 hold",
                {out_flag, out_result}, held);
        end
        was_stalled = out_valid && !out_ready;
        held = {out_flag, out_result};
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R11 unexpected beat", {out_flag, out_result}, '0);
          end else begin
            it = sb.pop_front();
            check({out_flag, out_result} == {it.flag, it.res}, it.tag,
                  {out_flag, out_result}, {it.flag, it.res});
          end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: empty after reset and ready to accept
    check(!out_valid && in_ready, "R11 reset", {64'b0, out_valid}, {64'b0, 1'b0});

    send(64'h0000_0000_DEAD_BEEF, {9'd0, 7'd8, 10'd0, 6'd4}, 1'b0, 1'b0, "R1 unsigned narrow");
    send(64'h0000_0000_DEAD_BEEF, {9'd0, 7'd8, 10'd0, 6'd4}, 1'b0, 1'b1, "R2 signed narrow");
    send(64'h0000_0000_DEAD_BEEF, {9'd0, 7'd0, 10'd0, 6'd4}, 1'b0, 1'b1, "R4 zero length");
    send(64'hFFFF_FFFF_FFFF_FFFF, {9'h1FF, 7'd0, 10'h3FF, 6'd63}, 1'b1, 1'b1, "R4 zero length wide");
    send(64'h0000_0000_DEAD_BEEF, {9'd0, 7'd8, 10'd0, 6'd28}, 1'b0, 1'b1, "R5 overflow signed");
    send(64'h0000_0000_DEAD_BEEF, {9'd0, 7'd100, 10'd0, 6'd28}, 1'b0, 1'b0, "R5 overflow unsigned");
    send(64'h8123_4567_89AB_CDEF, {9'd0, 7'd127, 10'd0, 6'd60}, 1'b1, 1'b1, "R5 overflow wide");
    send(64'h0123_4567_89AB_CDEF, {9'd0, 7'd16, 10'd0, 6'd40}, 1'b1, 1'b0, "R6 wide field");
    send(64'h0000_8000_0000_0000, {9'd0, 7'd8, 10'd0, 6'd40}, 1'b1, 1'b1, "R6 wide sign");
    send(64'h0000_0000_0000_00F0, {9'd0, 7'd4, 10'd0, 6'd36}, 1'b0, 1'b0, "R3 bit5 ignored narrow");
    send(64'h0000_0000_0000_00F0, {9'd0, 7'd4, 10'd0, 6'd36}, 1'b1, 1'b0, "R3 bit5 used wide");
    send(64'hFFFF_FFFF_0000_0000, {9'd0, 7'd40, 10'd0, 6'd0}, 1'b0, 1'b1, "R7 upper data ignored");
    send(64'h0000_0000_F000_0000, {9'd0, 7'd8, 10'd0, 6'd30}, 1'b0, 1'b1, "R7 upper result zero");
    send(64'h0000_0000_FFFF_00FF, {9'd0, 7'd8, 10'd0, 6'd8}, 1'b0, 1'b1, "R8 zero field flag");
    send(64'h0000_0000_1234_5678, {9'h1AB, 7'd12, 10'h2C5, 6'd4}, 1'b0, 1'b1, "R9 stray ctrl bits");
    send(64'h0000_0000_1234_5678, {9'h1AB, 7'd12, 10'h2C5, 6'd4}, 1'b1, 1'b0, "R9 stray ctrl wide");

    stall_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      send({$urandom, $urandom}, $urandom, 1'($urandom), 1'($urandom), "R1 R2 R5 R11 random");
    end
    stall_en = 1'b0;

    repeat (10) @(posedge clk);
    #1;
    check(sb.size() == 0, "R11 drained", {33'b0, 32'(sb.size())}, '0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule